// File: doc/BRIEF.md
# Handshaked Serial Word Sender

This block moves 16-bit words from a host processor to a remote node over a bit-serial link. Each bit crosses the link under a two-phase request/acknowledge exchange. The far end may take any amount of time to answer, so the block tolerates a pause of any length between any two bits. The only storage is the shift register itself.

A host write loads the shift register and starts the transfer. When a word has been shifted out, the block raises a data-request wakeup and waits for the next write or for a clear. A start command puts the sequencer straight into the waiting state, so the first word is fetched through the normal wakeup path and no priming write is needed. A last-word command given after a write makes the block send one extra marker bit after the current word, which closes a message. A loopback control sends the serial outputs to the local receiver and takes the acknowledge from that receiver, for self-test.

Top module: `hs_word_tx`

## Requirements
- R1: After reset, every output is 0 and the sequencer is idle.
- R2: A write that is sampled while the sequencer is idle or waiting loads the word, drops the wakeup and starts the transfer. The bits leave most significant bit first. On the edge after the write, data is presented with the strobe low. The strobe rises on the following edge.
- R3: The strobe stays high until the two-stage synchronised acknowledge is seen high. It then falls, and the next bit is presented. A new strobe is raised only after the acknowledge is seen low. Data and the marker line stay stable while the strobe is high. Stalls of any length are tolerated.
- R4: When the far end answers at once, each bit takes exactly 6 clock cycles, measured from one strobe rise to the next.
- R5: After the last bit's acknowledge has been released, the wakeup rises. It stays high until a write, a clear or a master reset is sampled. The strobe is never high while the wakeup is high.
- R6: A last-word command latches a flag. While the flag is set, the 16th bit is followed by one more strobe cycle in which the marker line is 1 and the data line is 0. The flag clears when that marker exchange completes, so the next word goes out without a marker.
- R7: A start command that is sampled while idle raises the wakeup on the next edge, with no write.
- R8: A clear returns the sequencer to idle on the next edge from any state. It drops the wakeup and the strobe. It leaves the last-word flag as it was.
- R9: A master reset does everything a clear does, and it also clears the last-word flag.
- R10: A write that arrives during a transfer is ignored. The word that is being sent completes unchanged.
- R11: With loopback set, the local outputs carry the strobe, data and marker, the external outputs are held at 0, and the acknowledge is taken from the local input. With loopback clear, the roles are reversed.
- R12: When several commands arrive in the same cycle, master reset wins over clear, clear wins over write, and write wins over start. The last-word command latches even when a clear arrives in the same cycle, but a master reset in the same cycle cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe: load the word and start the transfer |
| wr_data_i | input | 16 | Word to send |
| start_i | input | 1 | Output-start command |
| clr_i | input | 1 | Clear: return the sequencer to idle |
| mreset_i | input | 1 | Master reset: clear, and also drop the last-word flag |
| set_last_i | input | 1 | Last-word command |
| loopback_i | input | 1 | Send the outputs to the local receiver |
| ext_ack_i | input | 1 | Acknowledge from the external link |
| lb_ack_i | input | 1 | Acknowledge from the local receiver |
| ext_data_o | output | 1 | External serial data |
| ext_valid_o | output | 1 | External bit strobe |
| ext_last_o | output | 1 | External end-of-message marker |
| lb_data_o | output | 1 | Local serial data |
| lb_valid_o | output | 1 | Local bit strobe |
| lb_last_o | output | 1 | Local end-of-message marker |
| wake_o | output | 1 | Data-request wakeup |

## Verification
A command takes effect on the first edge that samples it. The wakeup responds on that same edge for start, write and clear. After a write, the strobe rises one edge later. An acknowledge change reaches the sequencer through two flops, so the strobe reacts on the third edge after the acknowledge moves. With an immediate far end, this gives three high cycles and three low cycles for each bit, and the wakeup appears three edges after the final strobe falls. Inputs change just after a rising edge. A behavioural model of these delays is stepped on every falling edge, and all seven outputs are compared against it there. Directed checks on received bit patterns, strobe spacing and wakeup levels are also taken on falling edges.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } tx_state_e;
endpackage

// File: rtl/hs_tx_sync.sv
module hs_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= {q_q[STAGES-2:0], d_i};
  end

  assign q_o = q_q[STAGES-1];
endmodule

// File: rtl/hs_tx_shifter.sv
module hs_tx_shifter #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              done_o
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign msb_o  = sh_q[WORD_W-1];
  assign done_o = (cnt_q == CNT_W'(WORD_W));
endmodule

// File: rtl/hs_tx_seq.sv
module hs_tx_seq
  import hs_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic start_i,
  input  logic clr_i,
  input  logic mreset_i,
  input  logic set_last_i,
  input  logic ack_i,
  input  logic done_i,
  output logic load_o,
  output logic shift_o,
  output logic active_o,
  output logic valid_o,
  output logic mark_o,
  output logic wake_o
);
  tx_state_e st_q, st_d;
  logic mark_q, mark_d;
  logic last_q, last_d;
  logic last_clr;

  always_comb begin
    st_d     = st_q;
    mark_d   = mark_q;
    load_o   = 1'b0;
    shift_o  = 1'b0;
    last_clr = 1'b0;
    if (mreset_i || clr_i) begin
      st_d   = ST_IDLE;
      mark_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_WAIT: begin
          if (wr_i) begin
            st_d   = ST_LOW;
            load_o = 1'b1;
          end else if (start_i) begin
            st_d = ST_WAIT;
          end
        end
        ST_LOW: begin
          // low phase doubles as data setup for the next strobe
          if (!ack_i) begin
            if (mark_q) begin
              st_d     = ST_WAIT;
              mark_d   = 1'b0;
              last_clr = 1'b1;
            end else if (!done_i) begin
              st_d = ST_HIGH;
            end else if (last_q) begin
              st_d   = ST_HIGH;
              mark_d = 1'b1;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        ST_HIGH: begin
          if (ack_i) begin
            st_d    = ST_LOW;
            shift_o = !mark_q;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (mreset_i)       last_d = 1'b0;
    else if (set_last_i) last_d = 1'b1;
    else if (last_clr)  last_d = 1'b0;
    else                last_d = last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mark_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mark_q <= mark_d;
      last_q <= last_d;
    end
  end

  assign active_o = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign valid_o  = (st_q == ST_HIGH);
  assign mark_o   = mark_q;
  assign wake_o   = (st_q == ST_WAIT);
endmodule

// File: rtl/hs_tx_route.sv
module hs_tx_route (
  input  logic loopback_i,
  input  logic data_i,
  input  logic valid_i,
  input  logic last_i,
  input  logic ext_ack_i,
  input  logic lb_ack_i,
  output logic ack_o,
  output logic ext_data_o,
  output logic ext_valid_o,
  output logic ext_last_o,
  output logic lb_data_o,
  output logic lb_valid_o,
  output logic lb_last_o
);
  always_comb begin
    ext_data_o  = !loopback_i && data_i;
    ext_valid_o = !loopback_i && valid_i;
    ext_last_o  = !loopback_i && last_i;
    lb_data_o   = loopback_i && data_i;
    lb_valid_o  = loopback_i && valid_i;
    lb_last_o   = loopback_i && last_i;
    ack_o       = loopback_i ? lb_ack_i : ext_ack_i;
  end
endmodule

// File: rtl/hs_word_tx.sv
module hs_word_tx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              clr_i,
  input  logic              mreset_i,
  input  logic              set_last_i,
  input  logic              loopback_i,
  input  logic              ext_ack_i,
  input  logic              lb_ack_i,
  output logic              ext_data_o,
  output logic              ext_valid_o,
  output logic              ext_last_o,
  output logic              lb_data_o,
  output logic              lb_valid_o,
  output logic              lb_last_o,
  output logic              wake_o
);
  logic ack_raw, ack_s;
  logic load, shift, done, msb;
  logic tx_active, tx_valid, tx_mark;
  logic ser_data, ser_last;

  hs_tx_route u_route (
    .loopback_i (loopback_i),
    .data_i     (ser_data),
    .valid_i    (tx_valid),
    .last_i     (ser_last),
    .ext_ack_i  (ext_ack_i),
    .lb_ack_i   (lb_ack_i),
    .ack_o      (ack_raw),
    .ext_data_o (ext_data_o),
    .ext_valid_o(ext_valid_o),
    .ext_last_o (ext_last_o),
    .lb_data_o  (lb_data_o),
    .lb_valid_o (lb_valid_o),
    .lb_last_o  (lb_last_o)
  );

  hs_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_raw),
    .q_o   (ack_s)
  );

  hs_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (wr_data_i),
    .shift_i(shift),
    .msb_o  (msb),
    .done_o (done)
  );

  hs_tx_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .start_i   (start_i),
    .clr_i     (clr_i),
    .mreset_i  (mreset_i),
    .set_last_i(set_last_i),
    .ack_i     (ack_s),
    .done_i    (done),
    .load_o    (load),
    .shift_o   (shift),
    .active_o  (tx_active),
    .valid_o   (tx_valid),
    .mark_o    (tx_mark),
    .wake_o    (wake_o)
  );

  // marker bit carries 0 on the data line
  assign ser_data = tx_active && !tx_mark && msb;
  assign ser_last = tx_active && tx_mark;
endmodule

// File: rtl/hs_word_tx_chk.sv
module hs_word_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic start_i,
  input logic clr_i,
  input logic mreset_i,
  input logic loopback_i,
  input logic ext_ack_i,
  input logic ext_data_o,
  input logic ext_valid_o,
  input logic ext_last_o,
  input logic lb_valid_o,
  input logic wake_o,
  input logic tx_active
);
  a_r3_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && $past(ext_valid_o)) |-> ($stable(ext_data_o) && $stable(ext_last_o)));

  a_r3_hold_for_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && !ext_ack_i && !loopback_i && !clr_i && !mreset_i) |=> ext_valid_o);

  a_r5_wake_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!ext_valid_o && !lb_valid_o));

  a_r2_write_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tx_active && !clr_i && !mreset_i) |=> (tx_active && !wake_o));

  a_r7_start_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !tx_active && !wr_i && !clr_i && !mreset_i) |=> wake_o);

  a_r8_clear_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || mreset_i) |=> (!wake_o && !ext_valid_o && !lb_valid_o && !tx_active));
endmodule

bind hs_word_tx hs_word_tx_chk u_chk (.*);

// File: tb/hs_word_tx_test.sv
`timescale 1ns/1ps
module hs_word_tx_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 0, start_i = 0, clr_i = 0, mreset_i = 0, set_last_i = 0, loopback_i = 0;
  logic [15:0] wr_data_i = '0;
  logic ext_ack, lb_ack;
  logic ext_data_o, ext_valid_o, ext_last_o, lb_data_o, lb_valid_o, lb_last_o, wake_o;

  always #2.5 clk = ~clk;

  hs_word_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .start_i(start_i), .clr_i(clr_i), .mreset_i(mreset_i), .set_last_i(set_last_i),
    .loopback_i(loopback_i), .ext_ack_i(ext_ack), .lb_ack_i(lb_ack),
    .ext_data_o(ext_data_o), .ext_valid_o(ext_valid_o), .ext_last_o(ext_last_o),
    .lb_data_o(lb_data_o), .lb_valid_o(lb_valid_o), .lb_last_o(lb_last_o),
    .wake_o(wake_o)
  );

  // far-end responders: ack follows strobe after a set delay
  int ext_dly = 0, lb_dly = 0;
  logic [63:0] ext_hist = '0, lb_hist = '0;
  always @(posedge clk) begin
    ext_hist <= {ext_hist[62:0], ext_valid_o};
    lb_hist  <= {lb_hist[62:0], lb_valid_o};
  end
  assign ext_ack = (ext_dly == 0) ? ext_valid_o : ext_hist[ext_dly-1];
  assign lb_ack  = (lb_dly == 0) ? lb_valid_o : lb_hist[lb_dly-1];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int ext_q[$], ext_t[$], lb_q[$];
  bit prev_ev = 0, prev_lv = 0;

  // reference model state
  int m_st = 0, m_sent = 0;
  logic [15:0] m_sh = '0;
  bit m_mark = 0, m_last = 0, m_s1 = 0, m_s2 = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit act, ackm, clrlast;
    logic [6:0] e, a;
    cyc++;
    if (ext_valid_o && !prev_ev) begin ext_q.push_back({ext_last_o, ext_data_o}); ext_t.push_back(cyc); end
    if (lb_valid_o && !prev_lv) lb_q.push_back({lb_last_o, lb_data_o});
    prev_ev = ext_valid_o;
    prev_lv = lb_valid_o;
    if (!rst_ni) begin
      m_st = 0; m_sent = 0; m_sh = '0; m_mark = 0; m_last = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      act = (m_st >= 2);
      e[6] = (m_st == 1);
      e[5] = !loopback_i && m_st == 3;
      e[4] = !loopback_i && act && !m_mark && m_sh[15];
      e[3] = !loopback_i && act && m_mark;
      e[2] = loopback_i && m_st == 3;
      e[1] = loopback_i && act && !m_mark && m_sh[15];
      e[0] = loopback_i && act && m_mark;
      a = {wake_o, ext_valid_o, ext_data_o, ext_last_o, lb_valid_o, lb_data_o, lb_last_o};
      if (a[6] != e[6]) chk(0, "R5", "wake per cycle", int'(a), int'(e));
      else if (loopback_i) chk(a == e, "R11", "loopback outputs per cycle", int'(a), int'(e));
      else chk(a == e, "R3", "link outputs per cycle", int'(a), int'(e));
      // step to the state after the coming rising edge
      ackm = loopback_i ? lb_ack : ext_ack;
      clrlast = 0;
      if (mreset_i || clr_i) begin
        m_st = 0; m_mark = 0;
      end else begin
        case (m_st)
          0, 1: if (wr_i) begin m_st = 2; m_sh = wr_data_i; m_sent = 0; end
                else if (start_i) m_st = 1;
          2: if (!m_s2) begin
               if (m_mark) begin m_st = 1; m_mark = 0; clrlast = 1; end
               else if (m_sent < 16) m_st = 3;
               else if (m_last) begin m_st = 3; m_mark = 1; end
               else m_st = 1;
             end
          default: if (m_s2) begin
               m_st = 2;
               if (!m_mark) begin m_sh = m_sh << 1; m_sent++; end
             end
        endcase
      end
      if (mreset_i) m_last = 0;
      else if (set_last_i) m_last = 1;
      else if (clrlast) m_last = 0;
      m_s2 = m_s1;
      m_s1 = ackm;
    end
  end

  task automatic cmd(bit w, bit s, bit c, bit m, bit sl, logic [15:0] d);
    @(posedge clk); #1;
    wr_i = w; start_i = s; clr_i = c; mreset_i = m; set_last_i = sl; wr_data_i = d;
    @(posedge clk); #1;
    wr_i = 0; start_i = 0; clr_i = 0; mreset_i = 0; set_last_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_wake(string tag);
    int k = 0;
    @(negedge clk);
    while (!wake_o && k < 20000) begin @(negedge clk); k++; end
    chk(wake_o, tag, "wakeup after word", int'(wake_o), 1);
  endtask

  task automatic check_word(string tag, int q[$], logic [15:0] w, bit mark);
    int n = mark ? 17 : 16;
    chk(q.size() == n, tag, "bit count", q.size(), n);
    for (int i = 0; i < 16 && i < q.size(); i++)
      chk(q[i] == int'(w[15-i]), tag, $sformatf("bit %0d", i), q[i], int'(w[15-i]));
    if (mark && q.size() == 17) chk(q[16] == 2, tag, "marker bit", q[16], 2);
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    // R1: reset state
    chk({wake_o, ext_valid_o, ext_data_o, ext_last_o, lb_valid_o, lb_data_o, lb_last_o} == 0,
        "R1", "outputs after reset", int'(wake_o), 0);

    // R7: start raises wakeup without a write
    cmd(0, 1, 0, 0, 0, '0);
    @(negedge clk);
    chk(wake_o, "R7", "wake after start", int'(wake_o), 1);

    // R2 / R4: immediate far end
    ext_q.delete(); ext_t.delete();
    cmd(1, 0, 0, 0, 0, 16'hA5C3);
    @(negedge clk);
    chk(!wake_o, "R2", "wake dropped by write", int'(wake_o), 0);
    wait_wake("R5");
    check_word("R2", ext_q, 16'hA5C3, 0);
    for (int i = 1; i < 16 && i < ext_t.size(); i++)
      chk(ext_t[i] - ext_t[i-1] == 6, "R4", "strobe spacing", ext_t[i] - ext_t[i-1], 6);
    idle(70);
    @(negedge clk);
    chk(wake_o, "R5", "wake held while waiting", int'(wake_o), 1);

    // R6 / R3: long stall with marker
    ext_dly = 37; ext_q.delete();
    cmd(1, 0, 0, 0, 0, 16'h8001);
    cmd(0, 0, 0, 0, 1, '0);
    wait_wake("R3");
    check_word("R6", ext_q, 16'h8001, 1);

    // R6: flag cleared after marker
    ext_q.delete();
    cmd(1, 0, 0, 0, 0, 16'h7FFE);
    wait_wake("R6");
    check_word("R6", ext_q, 16'h7FFE, 0);
    idle(80);

    // R10: write during transfer ignored
    ext_dly = 0; ext_q.delete();
    cmd(1, 0, 0, 0, 0, 16'h1234);
    idle(10);
    cmd(1, 0, 0, 0, 0, 16'hFFFF);
    wait_wake("R10");
    check_word("R10", ext_q, 16'h1234, 0);

    // R8: clear mid transfer
    cmd(1, 0, 0, 0, 0, 16'hFFFF);
    idle(20);
    cmd(0, 0, 1, 0, 0, '0);
    @(negedge clk);
    chk(!wake_o && !ext_valid_o, "R8", "idle after clear", int'({wake_o, ext_valid_o}), 0);
    idle(10);
    // R8: clear keeps last-word flag
    ext_q.delete();
    cmd(0, 0, 0, 0, 1, '0);
    cmd(0, 0, 1, 0, 0, '0);
    cmd(1, 0, 0, 0, 0, 16'h0F0F);
    wait_wake("R8");
    check_word("R8", ext_q, 16'h0F0F, 1);

    // R9: master reset drops last-word flag
    ext_q.delete();
    cmd(0, 0, 0, 0, 1, '0);
    cmd(0, 0, 0, 1, 0, '0);
    @(negedge clk);
    chk(!wake_o, "R9", "idle after master reset", int'(wake_o), 0);
    cmd(1, 0, 0, 0, 0, 16'h3C3C);
    wait_wake("R9");
    check_word("R9", ext_q, 16'h3C3C, 0);

    // R11: loopback path
    loopback_i = 1; lb_dly = 3; ext_q.delete(); lb_q.delete();
    cmd(1, 0, 0, 0, 1, 16'hC0DE);
    wait_wake("R11");
    check_word("R11", lb_q, 16'hC0DE, 1);
    chk(ext_q.size() == 0, "R11", "external strobes in loopback", ext_q.size(), 0);
    idle(5);
    loopback_i = 0;
    idle(5);

    // R12: command priority
    ext_q.delete();
    cmd(1, 1, 0, 0, 0, 16'h0001);
    @(negedge clk);
    chk(!wake_o, "R12", "write beats start", int'(wake_o), 0);
    wait_wake("R12");
    check_word("R12", ext_q, 16'h0001, 0);
    ext_q.delete();
    cmd(1, 0, 1, 0, 0, 16'hFFFF);
    idle(20);
    @(negedge clk);
    chk(!wake_o && ext_q.size() == 0, "R12", "clear beats write", ext_q.size(), 0);
    cmd(0, 1, 0, 1, 0, '0);
    @(negedge clk);
    chk(!wake_o, "R12", "master reset beats start", int'(wake_o), 0);
    cmd(0, 1, 1, 0, 0, '0);
    @(negedge clk);
    chk(!wake_o, "R12", "clear beats start", int'(wake_o), 0);
    idle(5);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule